// File: doc/BRIEF.md
# Segment Selector Translation and Protection Unit

This block holds one segment register of a processor that runs either in a flat real-address mode or in a protected mode. When a 16-bit selector is loaded in protected mode, the block picks one of two descriptor tables in memory: a global table shared by all tasks, or a local table owned by the current task. It reads the matching 8-byte descriptor over a 16-bit memory read port and keeps the base, limit and privilege level of that descriptor in a private cache. Every later access gives an offset and the current privilege level. The block checks the access against the cached limit and privilege and returns either a 24-bit physical address or a general-protection fault.

When the protection-enable bit (bit 0 of the mode control register, wired to `prot_en`) is clear, a load only latches the selector. Each access is then translated as selector times sixteen plus the offset, with no checks. While a descriptor fetch is in progress the unit is busy, and it refuses access requests until the cache holds the new descriptor.

Top module: `seg_xlate_unit`

## Requirements
- R1: A selector has its table index in bits 15:3, the table-select bit in bit 2 (0 = global table at `glob_base`, 1 = local table at `loc_base`) and the requested privilege level (RPL) in bits 1:0. The descriptor's byte address is the table base plus index × 8.
- R2: A protected-mode load of a non-null selector issues exactly four 16-bit reads at descriptor address +0, +2, +4 and +6, on consecutive cycles. Read data is expected on `rd_data` in the cycle after the cycle in which `rd_en` was sampled high.
- R3: `busy` is high for exactly five cycles after a fetching load. While `busy` is high, `acc_ready` is low and access requests are ignored, so they produce no `out_valid`. Loads are accepted only while `busy` is low.
- R4: The descriptor words are laid out as follows. Word 0 holds limit[15:0]. Word 1 holds base[15:0]. Word 2 holds base[23:16] in bits 7:0 and the access byte in bits 15:8, with the descriptor privilege level (DPL) in bits 14:13. Word 3 holds limit[19:16] in bits 3:0. All other bits are ignored.
- R5: A protected-mode access that does not fault returns base + offset, modulo 2^24.
- R6: A protected-mode access whose offset is greater than the 20-bit limit faults. An offset equal to the limit is allowed.
- R7: A protected-mode access is allowed only if max(CPL, RPL) ≤ DPL, where ring 0 is the most privileged and ring 3 the least.
- R8: A faulting access drives `out_gpf` high and `out_addr` to zero.
- R9: A selector with index 0 and table-select 0 (the null selector) loads without any memory read and without raising `busy`. Every protected-mode access through it faults. After reset the register holds the null selector.
- R10: With `prot_en` low, a load performs no reads. An access returns selector × 16 + offset[15:0], never faults, and ignores CPL, RPL and offset bits 19:16.
- R11: The result appears on `out_valid`/`out_addr`/`out_gpf` in the cycle after an access is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prot_en | input | 1 | Protection-enable bit of the mode control register |
| glob_base | input | 24 | Byte address of the global descriptor table |
| loc_base | input | 24 | Byte address of the local descriptor table |
| ld_valid | input | 1 | Load `ld_sel` into the segment register |
| ld_sel | input | 16 | Selector to load |
| busy | output | 1 | Descriptor fetch in progress |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | 24 | Byte address of the 16-bit word to read |
| rd_data | input | 16 | Read data, one cycle after the request |
| acc_valid | input | 1 | Access request |
| acc_ready | output | 1 | Access requests are accepted this cycle |
| acc_offset | input | 20 | Offset within the segment |
| acc_cpl | input | 2 | Current privilege level of the access |
| out_valid | output | 1 | Translation result valid |
| out_addr | output | 24 | Physical address (zero on fault) |
| out_gpf | output | 1 | General-protection fault |

## Verification
The hardest case to reach is the interplay between a descriptor fetch and accesses that arrive while it is still in progress. The stimulus reaches it by driving an access request on every cycle of a fetch. It then checks that none of these requests produces a result, including the request in the cycle where `busy` drops. Privilege and limit checks are swept across every descriptor in both tables, all four RPL values, all four CPL values and the offsets 0, limit and limit+1. One local descriptor sits near the top of the address space so that the address wraps.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int DESC_WORDS = 4;   // 16-bit words per descriptor
  localparam int IDX_LSB    = 3;   // selector index field starts here
  localparam int TSEL_BIT   = 2;   // table-select bit
  localparam int RPL_W      = 2;   // privilege field width
  localparam int DPL_LSB    = 13;  // DPL position inside descriptor word 2

  function automatic logic [RPL_W-1:0] ring_max(input logic [RPL_W-1:0] a,
                                                input logic [RPL_W-1:0] b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch
  import seg_pkg::*;
#(
  parameter int AW    = 24,
  parameter int DW    = 16,
  parameter int SEL_W = 16,
  parameter int LIM_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             prot_en,
  input  logic [AW-1:0]    glob_base,
  input  logic [AW-1:0]    loc_base,
  input  logic             ld_valid,
  input  logic [SEL_W-1:0] ld_sel,
  output logic             busy,
  output logic             rd_en,
  output logic [AW-1:0]    rd_addr,
  input  logic [DW-1:0]    rd_data,
  output logic [SEL_W-1:0] c_sel,
  output logic             c_null,
  output logic [AW-1:0]    c_base,
  output logic [LIM_W-1:0] c_limit,
  output logic [RPL_W-1:0] c_dpl,
  output logic [RPL_W-1:0] c_rpl
);
  localparam int CNT_W   = $clog2(DESC_WORDS);
  localparam int BYTES_W = DW / 8;
  localparam int LIM_HI  = LIM_W - DW;
  localparam int BASE_HI = AW - DW;

  logic [DW-1:0]    wbuf [DESC_WORDS];
  logic [CNT_W-1:0] issue_cnt, cap_cnt;
  logic             pend;
  logic             sel_null;
  logic [AW-1:0]    tbase, dsc_addr;

  assign sel_null = (ld_sel[SEL_W-1:IDX_LSB] == '0) && !ld_sel[TSEL_BIT];
  assign tbase    = ld_sel[TSEL_BIT] ? loc_base : glob_base;
  assign dsc_addr = tbase + AW'({ld_sel[SEL_W-1:IDX_LSB], 3'b000});

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      rd_en     <= 1'b0;
      rd_addr   <= '0;
      pend      <= 1'b0;
      issue_cnt <= '0;
      cap_cnt   <= '0;
      c_sel     <= '0;
      c_null    <= 1'b1;
      c_base    <= '0;
      c_limit   <= '0;
      c_dpl     <= '0;
      c_rpl     <= '0;
    end else begin
      pend <= rd_en;
      if (!busy) begin
        if (ld_valid) begin
          c_sel  <= ld_sel;
          c_rpl  <= ld_sel[RPL_W-1:0];
          c_null <= sel_null;
          if (prot_en && !sel_null) begin
            busy      <= 1'b1;
            rd_en     <= 1'b1;
            rd_addr   <= dsc_addr;
            issue_cnt <= '0;
            cap_cnt   <= '0;
          end
        end
      end else begin
        if (rd_en) begin
          if (issue_cnt == CNT_W'(DESC_WORDS - 1)) begin
            rd_en <= 1'b0;
          end else begin
            rd_addr <= rd_addr + AW'(BYTES_W);
          end
          issue_cnt <= issue_cnt + 1'b1;
        end
        if (pend) begin
          wbuf[cap_cnt] <= rd_data;
          cap_cnt       <= cap_cnt + 1'b1;
          if (cap_cnt == CNT_W'(DESC_WORDS - 1)) begin
            busy    <= 1'b0;
            c_limit <= {rd_data[LIM_HI-1:0], wbuf[0]};
            c_base  <= {wbuf[2][BASE_HI-1:0], wbuf[1]};
            c_dpl   <= wbuf[2][DPL_LSB +: RPL_W];
          end
        end
      end
    end
  end

  // R3
  rd_busy_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> busy);

  // R2
  rd_stride_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + AW'(BYTES_W)));

  // R9
  null_noread_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && !busy && sel_null) |=> !busy);
endmodule

// File: rtl/seg_access_check.sv
module seg_access_check
  import seg_pkg::*;
#(
  parameter int AW    = 24,
  parameter int SEL_W = 16,
  parameter int OFF_W = 20,
  parameter int LIM_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             prot_en,
  input  logic             acc_fire,
  input  logic [OFF_W-1:0] acc_offset,
  input  logic [RPL_W-1:0] acc_cpl,
  input  logic [SEL_W-1:0] c_sel,
  input  logic             c_null,
  input  logic [AW-1:0]    c_base,
  input  logic [LIM_W-1:0] c_limit,
  input  logic [RPL_W-1:0] c_dpl,
  input  logic [RPL_W-1:0] c_rpl,
  output logic             out_valid,
  output logic [AW-1:0]    out_addr,
  output logic             out_gpf
);
  localparam int RM_OFF_W = 16;
  localparam int RM_SHIFT = 4;

  logic          priv_bad, lim_bad, fault;
  logic [AW-1:0] paddr;

  assign priv_bad = ring_max(acc_cpl, c_rpl) > c_dpl;
  assign lim_bad  = LIM_W'(acc_offset) > c_limit;
  assign fault    = prot_en && (c_null || priv_bad || lim_bad);
  assign paddr    = prot_en ? (c_base + AW'(acc_offset))
                            : (AW'({c_sel, RM_SHIFT'(0)}) + AW'(acc_offset[RM_OFF_W-1:0]));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_gpf   <= 1'b0;
    end else begin
      out_valid <= acc_fire;
      if (acc_fire) begin
        out_gpf  <= fault;
        out_addr <= fault ? '0 : paddr;
      end else begin
        out_gpf  <= 1'b0;
      end
    end
  end

  // R8
  gpf_zero_chk: assert property (@(posedge clk) disable iff (rst)
    out_gpf |-> (out_valid && out_addr == '0));

  // R11
  resp_lat_chk: assert property (@(posedge clk) disable iff (rst)
    acc_fire |=> out_valid);

  // R10
  real_nofault_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_fire && !prot_en) |=> !out_gpf);

  // R9
  null_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_fire && prot_en && c_null) |=> out_gpf);
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_pkg::*;
#(
  parameter int AW    = 24,
  parameter int DW    = 16,
  parameter int SEL_W = 16,
  parameter int OFF_W = 20,
  parameter int LIM_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             prot_en,
  input  logic [AW-1:0]    glob_base,
  input  logic [AW-1:0]    loc_base,
  input  logic             ld_valid,
  input  logic [SEL_W-1:0] ld_sel,
  output logic             busy,
  output logic             rd_en,
  output logic [AW-1:0]    rd_addr,
  input  logic [DW-1:0]    rd_data,
  input  logic             acc_valid,
  output logic             acc_ready,
  input  logic [OFF_W-1:0] acc_offset,
  input  logic [1:0]       acc_cpl,
  output logic             out_valid,
  output logic [AW-1:0]    out_addr,
  output logic             out_gpf
);
  logic [SEL_W-1:0] c_sel;
  logic             c_null;
  logic [AW-1:0]    c_base;
  logic [LIM_W-1:0] c_limit;
  logic [RPL_W-1:0] c_dpl, c_rpl;
  logic             acc_fire;

  assign acc_ready = !busy;
  assign acc_fire  = acc_valid && !busy;

  seg_desc_fetch #(.AW(AW), .DW(DW), .SEL_W(SEL_W), .LIM_W(LIM_W)) u_fetch (
    .clk(clk), .rst(rst), .prot_en(prot_en),
    .glob_base(glob_base), .loc_base(loc_base),
    .ld_valid(ld_valid), .ld_sel(ld_sel),
    .busy(busy), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .c_sel(c_sel), .c_null(c_null), .c_base(c_base), .c_limit(c_limit),
    .c_dpl(c_dpl), .c_rpl(c_rpl)
  );

  seg_access_check #(.AW(AW), .SEL_W(SEL_W), .OFF_W(OFF_W), .LIM_W(LIM_W)) u_check (
    .clk(clk), .rst(rst), .prot_en(prot_en), .acc_fire(acc_fire),
    .acc_offset(acc_offset), .acc_cpl(acc_cpl),
    .c_sel(c_sel), .c_null(c_null), .c_base(c_base), .c_limit(c_limit),
    .c_dpl(c_dpl), .c_rpl(c_rpl),
    .out_valid(out_valid), .out_addr(out_addr), .out_gpf(out_gpf)
  );

  // R3
  stall_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> !out_valid);
endmodule

// File: tb/seg_xlate_unit_test.sv
module seg_xlate_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [23:0] GB = 24'h000100;
  localparam logic [23:0] LB = 24'h000400;

  logic        clk = 0, rst = 1, prot_en = 0;
  logic        ld_valid = 0, acc_valid = 0;
  logic [15:0] ld_sel = 0;
  logic [19:0] acc_offset = 0;
  logic [1:0]  acc_cpl = 0;
  logic [15:0] rd_data;
  logic        busy, rd_en, acc_ready, out_valid, out_gpf;
  logic [23:0] rd_addr, out_addr;

  int total = 0, bad = 0, cyc = 0, rd_total = 0;
  logic [15:0] mem [1024];
  logic [23:0] rdlog [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_xlate_unit uut (
    .clk(clk), .rst(rst), .prot_en(prot_en), .glob_base(GB), .loc_base(LB),
    .ld_valid(ld_valid), .ld_sel(ld_sel), .busy(busy), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .acc_valid(acc_valid),
    .acc_ready(acc_ready), .acc_offset(acc_offset), .acc_cpl(acc_cpl),
    .out_valid(out_valid), .out_addr(out_addr), .out_gpf(out_gpf)
  );

  always @(posedge clk) begin
    if (rd_en) begin
      rd_data <= mem[rd_addr[10:1]];
      rdlog[rd_total % 16] <= rd_addr;
      rd_total <= rd_total + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      $display("FAIL watchdog: act=%0d exp<150000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
      $finish;
    end
  end

  function automatic logic [23:0] d_base(int t, int i);
    if (t == 1 && i == 7) return 24'hFFFF00;
    return 24'h020000 + 24'(i) * 24'h011111 + 24'(t) * 24'h300000;
  endfunction
  function automatic logic [19:0] d_lim(int t, int i);
    return 20'h00400 + 20'(i) * 20'h02345 + (t == 1 ? 20'h10000 : 20'h0);
  endfunction
  function automatic logic [1:0] d_dpl(int t, int i);
    return 2'((i + t) % 4);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Load a selector; returns number of busy cycles observed.
  task automatic do_load(input logic [15:0] s, output int bc);
    @(negedge clk); ld_valid = 1; ld_sel = s;
    @(negedge clk); ld_valid = 0; bc = 0;
    while (busy && bc < 50) begin bc++; @(negedge clk); end
  endtask

  task automatic do_acc(input logic [19:0] off, input logic [1:0] cpl,
                        input bit exp_f, input logic [23:0] exp_a, input string tag);
    @(negedge clk); acc_valid = 1; acc_offset = off; acc_cpl = cpl;
    @(negedge clk); acc_valid = 0;
    chk(out_valid == 1'b1, {tag, " valid (R11)"}, 32'(out_valid), 1);
    chk(out_gpf == exp_f, {tag, " gpf"}, 32'(out_gpf), 32'(exp_f));
    chk(out_addr == (exp_f ? 24'h0 : exp_a), {tag, " addr"}, 32'(out_addr), 32'(exp_f ? 24'h0 : exp_a));
  endtask

  initial begin
    int bc, st;
    for (int k = 0; k < 1024; k++) mem[k] = 16'hDEAD;
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < 8; i++) begin
        int wa;
        wa = int'(((t == 1 ? LB : GB) + 24'(i * 8)) >> 1);
        mem[wa]     = d_lim(t, i)[15:0];
        mem[wa + 1] = d_base(t, i)[15:0];
        mem[wa + 2] = {1'b1, d_dpl(t, i), 5'b10010, d_base(t, i)[23:16]};
        mem[wa + 3] = {12'hA5C, d_lim(t, i)[19:16]};
      end

    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // reset state
    chk(busy == 0 && rd_en == 0 && out_valid == 0 && acc_ready == 1, "reset R3",
        {28'h0, busy, rd_en, out_valid, acc_ready}, 32'h1);

    // R10: real mode right after reset: selector 0
    prot_en = 0;
    do_acc(20'hF1234, 2'd3, 0, 24'h001234, "R10 reset real");
    // R9: reset holds null selector -> protected access faults
    prot_en = 1;
    do_acc(20'h0, 2'd0, 1, 24'h0, "R9 reset null");

    // R9: explicit null load (RPL 3) performs no reads, no busy
    st = rd_total;
    do_load(16'h0003, bc);
    chk(bc == 0, "R9 null busy", 32'(bc), 0);
    chk(rd_total == st, "R9 null reads", 32'(rd_total - st), 0);
    do_acc(20'h00010, 2'd0, 1, 24'h0, "R9 null acc");

    // R1 R2 R4 R5 R6 R7: sweep both tables, indices, RPL, CPL, offsets
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < 8; i++) begin
        if (t == 0 && i == 0) continue;
        for (int rpl = 0; rpl < 4; rpl++) begin
          logic [15:0] s;
          logic [23:0] da;
          s = {13'(i), 1'(t), 2'(rpl)};
          da = (t == 1 ? LB : GB) + 24'(i * 8);
          st = rd_total;
          do_load(s, bc);
          chk(bc == 5, "R3 busy length", 32'(bc), 5);
          chk(rd_total - st == 4, "R2 read count", 32'(rd_total - st), 4);
          for (int k = 0; k < 4; k++)
            chk(rdlog[(st + k) % 16] == da + 24'(2 * k), "R1 R2 read addr",
                32'(rdlog[(st + k) % 16]), 32'(da + 24'(2 * k)));
          for (int cpl = 0; cpl < 4; cpl++)
            for (int k = 0; k < 4; k++) begin
              logic [19:0] off;
              bit f;
              int eff;
              case (k)
                0: off = 20'h0;
                1: off = d_lim(t, i);
                2: off = d_lim(t, i) + 20'h1;
                default: off = d_lim(t, i) >> 1;
              endcase
              eff = (cpl > rpl) ? cpl : rpl;
              f = (eff > int'(d_dpl(t, i))) || (off > d_lim(t, i));
              do_acc(off, 2'(cpl), f, d_base(t, i) + 24'(off), "R4 R5 R6 R7 R8 prot");
            end
        end
      end

    // R3: access requests during a fetch are ignored
    st = rd_total;
    @(negedge clk); ld_valid = 1; ld_sel = {13'd3, 1'b1, 2'd0};
    @(negedge clk); ld_valid = 0;
    bc = 0;
    while (bc < 50) begin
      if (busy) begin
        chk(acc_ready == 0, "R3 ready low", 32'(acc_ready), 0);
        chk(out_valid == 0, "R3 stall", 32'(out_valid), 0);
        acc_valid = 1; acc_offset = 20'h10; acc_cpl = 0;
        bc++;
        @(negedge clk);
      end else begin
        chk(out_valid == 0, "R3 stall edge", 32'(out_valid), 0);
        acc_valid = 0;
        break;
      end
    end
    chk(bc == 5, "R3 busy length stalled", 32'(bc), 5);
    do_acc(20'h10, 2'd0, 0, d_base(1, 3) + 24'h10, "R3 after stall");

    // R10: real-mode sweep, no reads, no checks
    prot_en = 0;
    for (int j = 0; j < 4; j++) begin
      logic [15:0] s;
      case (j)
        0: s = 16'hF000;
        1: s = 16'h1234;
        2: s = 16'hFFFF;
        default: s = 16'h000B;
      endcase
      st = rd_total;
      do_load(s, bc);
      chk(bc == 0 && rd_total == st, "R10 no fetch", 32'(rd_total - st), 0);
      for (int k = 0; k < 3; k++) begin
        logic [19:0] off;
        off = (k == 0) ? 20'h0 : (k == 1) ? 20'h0FFFF : 20'hA5678;
        do_acc(off, 2'd0, 0, 24'({s, 4'h0}) + 24'(off[15:0]), "R10 real");
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule